// File: doc/BRIEF.md
# Credit-Returning Ring Stop

This block is one stop on a synchronous ring that runs in one direction and carries one-byte messages between up to 32 stops. Every cycle a word arrives on the ring input and a word leaves on the ring output; the ring never stalls. The stop adds two register stages to the ring. A word neither addressed to this stop nor coming back to it passes through both stages unchanged. A word addressed to this stop is taken off the ring and stored in a one-byte slot kept for its sender. A word whose sender is this stop has made the full loop. It is taken off the ring and gives back one send credit for the stop it was addressed to.

The local side sends through a valid/ready port. A handshake completes only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low in three cases: no credit is held for `tx_dst`, the first ring stage holds a word in transit, or a credit-return word is waiting to go out. While `tx_ready` is low, the sender keeps `tx_valid`, `tx_dst` and `tx_data` steady. The local side receives by picking a sender with `rx_sel`, seeing that slot's byte on `rx_data`, and pulsing `rx_rd` to consume it. When a slot is consumed, the stored message is sent back onto the ring unchanged. It travels on to its sender and returns that sender's credit. A word sent to an ID that no stop owns also comes back around, so its credit is returned the same way.

The ring side has no back-pressure. The environment must not deliver a second byte from a sender whose slot is still full or whose return is still pending. The credit scheme guarantees this on a correct ring.

Top module: `ring_node`

## Requirements
- R1: After reset, `ring_out_vld` is 0 and all `rx_flags` are 0. The stop holds one credit for every ID except its own, so `tx_ready` is 1 for any other `tx_dst` while the ring is idle.
- R2: A valid input word whose source and destination both differ from the stop's ID appears on the ring output two cycles later, with source, destination and byte unchanged.
- R3: A valid input word whose destination is the stop's ID, and whose source is not, never reaches the ring output. From the next cycle, bit `src` of `rx_flags` is 1 and `rx_data` shows its byte when `rx_sel` equals `src`.
- R4: A valid input word whose source is the stop's ID never reaches the ring output. From the next cycle, the credit for its destination is held again. This holds even for a destination ID that no stop owns.
- R5: A handshake on the send port puts the word {source = own ID, destination = `tx_dst`, byte = `tx_data`} on the ring output one cycle later. It also uses up the credit for that destination, so `tx_ready` stays low for that destination until the word returns.
- R6: A local word goes out only into a slot left empty by the ring. `tx_ready` is low in any cycle that follows a cycle in which a pass-through word entered.
- R7: Pulsing `rx_rd` while the selected slot is full clears that flag from the next cycle. The word {source = `rx_sel`, destination = own ID, same byte} then goes onto the ring at the first free slot, at the earliest two cycles after the pulse.
- R8: Pulsing `rx_rd` on an empty slot has no effect: no word goes onto the ring and `rx_flags` do not change.
- R9: Waiting credit-return words go out before new sends, lowest source ID first. `tx_ready` is low while any is waiting.
- R10: `tx_ready` is never high when `tx_dst` equals the stop's own ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_vld | input | 1 | Ring input word valid |
| ring_in_src | input | 5 | Ring input source ID |
| ring_in_dst | input | 5 | Ring input destination ID |
| ring_in_data | input | 8 | Ring input byte |
| ring_out_vld | output | 1 | Ring output word valid |
| ring_out_src | output | 5 | Ring output source ID |
| ring_out_dst | output | 5 | Ring output destination ID |
| ring_out_data | output | 8 | Ring output byte |
| tx_valid | input | 1 | Local send request |
| tx_ready | output | 1 | Local send accepted this cycle when high with `tx_valid` |
| tx_dst | input | 5 | Destination ID of the local send |
| tx_data | input | 8 | Byte of the local send |
| rx_rd | input | 1 | Consume the selected receive slot |
| rx_sel | input | 5 | Sender ID whose slot is selected |
| rx_data | output | 8 | Byte held in the selected slot |
| rx_flags | output | 32 | Per-sender full flags, bit i for sender i |

## Verification
A pass-through word is due on the ring output two edges after it enters. A local send is due one edge after its handshake. A credit-return word is due two edges after its `rx_rd` pulse, or later by one cycle for each transit word or earlier return ahead of it. Flags and credits change at the first edge after their cause. The bench keeps a behavioural model that advances by these rules at each rising edge. It compares the ring output, `tx_ready`, `rx_flags` and `rx_data` one time unit after each falling edge, once the inputs for that cycle are settled, so every result is checked in the exact cycle it is due.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int RING_ID_W   = 5;
  localparam int RING_DATA_W = 8;
  localparam int RING_NODES  = 1 << RING_ID_W;

  typedef struct packed {
    logic                   vld;
    logic [RING_ID_W-1:0]   src;
    logic [RING_ID_W-1:0]   dst;
    logic [RING_DATA_W-1:0] data;
  } ring_word_t;
endpackage

// File: rtl/ring_hop_pipe.sv
// Two register stages of the ring: stage A takes the ring input (or a
// bubble when the word is consumed here), stage B takes stage A or, when
// stage A is empty, a locally inserted word.
module ring_hop_pipe
  import ring_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ring_word_t in_word,
  input  logic       drop,
  input  logic       ins_valid,
  input  ring_word_t ins_word,
  output logic       hold_busy,
  output ring_word_t out_word
);
  ring_word_t stage_a_q;
  ring_word_t stage_b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_a_q <= '0;
      stage_b_q <= '0;
    end else begin
      stage_a_q <= (drop || !in_word.vld) ? '0 : in_word;
      if (stage_a_q.vld)
        stage_b_q <= stage_a_q;
      else if (ins_valid)
        stage_b_q <= ins_word;
      else
        stage_b_q <= '0;
    end
  end

  assign hold_busy = stage_a_q.vld;
  assign out_word  = stage_b_q;
endmodule

// File: rtl/ring_rx_bank.sv
// Per-sender one-byte slots with full flags and return-pending flags.
module ring_rx_bank
  import ring_pkg::*;
#(
  parameter int NODES  = RING_NODES,
  parameter int ID_W   = RING_ID_W,
  parameter int DATA_W = RING_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_src,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ID_W-1:0]   rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [NODES-1:0]  full_vec,
  output logic [NODES-1:0]  owed_vec,
  input  logic              ret_take,
  output logic              ret_any,
  output logic [ID_W-1:0]   ret_src,
  output logic [DATA_W-1:0] ret_data
);
  logic [DATA_W-1:0] byte_arr [NODES];
  logic              rd_ok;

  assign rd_ok = rd_en && full_vec[rd_sel];

  for (genvar g = 0; g < NODES; g++) begin : g_slot
    localparam logic [ID_W-1:0] SLOT_ID = ID_W'(g);
    logic [DATA_W-1:0] byte_q;
    logic              full_q;
    logic              owed_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= '0;
        full_q <= 1'b0;
        owed_q <= 1'b0;
      end else begin
        if (wr_en && wr_src == SLOT_ID) begin
          byte_q <= wr_data;
          full_q <= 1'b1;
        end else if (rd_ok && rd_sel == SLOT_ID) begin
          full_q <= 1'b0;
        end
        if (rd_ok && rd_sel == SLOT_ID)
          owed_q <= 1'b1;
        else if (ret_take && ret_src == SLOT_ID)
          owed_q <= 1'b0;
      end
    end

    assign byte_arr[g]  = byte_q;
    assign full_vec[g]  = full_q;
    assign owed_vec[g]  = owed_q;
  end

  // Lowest pending sender wins.
  always_comb begin
    ret_src = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (owed_vec[i]) ret_src = ID_W'(i);
    end
  end

  assign ret_any  = |owed_vec;
  assign ret_data = byte_arr[ret_src];
  assign rd_data  = byte_arr[rd_sel];
endmodule

// File: rtl/ring_credit_bank.sv
// One send credit per destination; none for the stop's own ID.
module ring_credit_bank
  import ring_pkg::*;
#(
  parameter int NODES   = RING_NODES,
  parameter int ID_W    = RING_ID_W,
  parameter int NODE_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_en,
  input  logic [ID_W-1:0]  take_dst,
  input  logic             give_en,
  input  logic [ID_W-1:0]  give_dst,
  input  logic [ID_W-1:0]  query_dst,
  output logic             has_credit,
  output logic [NODES-1:0] cred_vec
);
  for (genvar g = 0; g < NODES; g++) begin : g_cred
    localparam logic [ID_W-1:0] SLOT_ID  = ID_W'(g);
    localparam logic            INIT_VAL = (g != NODE_ID);
    logic cred_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        cred_q <= INIT_VAL;
      else if (give_en && give_dst == SLOT_ID)
        cred_q <= 1'b1;
      else if (take_en && take_dst == SLOT_ID)
        cred_q <= 1'b0;
    end

    assign cred_vec[g] = cred_q;
  end

  assign has_credit = cred_vec[query_dst];
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_pkg::*;
#(
  parameter int NODE_ID = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ring_in_vld,
  input  logic [RING_ID_W-1:0]   ring_in_src,
  input  logic [RING_ID_W-1:0]   ring_in_dst,
  input  logic [RING_DATA_W-1:0] ring_in_data,
  output logic                   ring_out_vld,
  output logic [RING_ID_W-1:0]   ring_out_src,
  output logic [RING_ID_W-1:0]   ring_out_dst,
  output logic [RING_DATA_W-1:0] ring_out_data,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  input  logic [RING_ID_W-1:0]   tx_dst,
  input  logic [RING_DATA_W-1:0] tx_data,
  input  logic                   rx_rd,
  input  logic [RING_ID_W-1:0]   rx_sel,
  output logic [RING_DATA_W-1:0] rx_data,
  output logic [RING_NODES-1:0]  rx_flags
);
  localparam int NODES = RING_NODES;
  localparam logic [RING_ID_W-1:0] MY_ID = RING_ID_W'(NODE_ID);

  ring_word_t in_word, ins_word, out_word;
  logic       from_me, to_me, drop;
  logic       hold_busy, has_credit, send_fire, ret_take, ins_valid;
  logic       ret_any;
  logic [RING_ID_W-1:0]   ret_src;
  logic [RING_DATA_W-1:0] ret_data;
  logic [NODES-1:0]       cred_vec;
  logic [NODES-1:0]       ret_pend;

  assign in_word = '{vld: ring_in_vld, src: ring_in_src, dst: ring_in_dst, data: ring_in_data};

  // Classify the arriving word.
  assign from_me = ring_in_vld && (ring_in_src == MY_ID);
  assign to_me   = ring_in_vld && !from_me && (ring_in_dst == MY_ID);
  assign drop    = from_me || to_me;

  // Insertion: credit returns first, then a local send.
  assign tx_ready  = !hold_busy && !ret_any && has_credit;
  assign send_fire = tx_valid && tx_ready;
  assign ret_take  = ret_any && !hold_busy;
  assign ins_valid = ret_take || send_fire;

  always_comb begin
    if (ret_any)
      ins_word = '{vld: 1'b1, src: ret_src, dst: MY_ID, data: ret_data};
    else
      ins_word = '{vld: 1'b1, src: MY_ID, dst: tx_dst, data: tx_data};
  end

  ring_hop_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_word   (in_word),
    .drop      (drop),
    .ins_valid (ins_valid),
    .ins_word  (ins_word),
    .hold_busy (hold_busy),
    .out_word  (out_word)
  );

  ring_rx_bank #(
    .NODES  (NODES),
    .ID_W   (RING_ID_W),
    .DATA_W (RING_DATA_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (to_me),
    .wr_src   (ring_in_src),
    .wr_data  (ring_in_data),
    .rd_en    (rx_rd),
    .rd_sel   (rx_sel),
    .rd_data  (rx_data),
    .full_vec (rx_flags),
    .owed_vec (ret_pend),
    .ret_take (ret_take),
    .ret_any  (ret_any),
    .ret_src  (ret_src),
    .ret_data (ret_data)
  );

  ring_credit_bank #(
    .NODES   (NODES),
    .ID_W    (RING_ID_W),
    .NODE_ID (NODE_ID)
  ) u_cred (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_en    (send_fire),
    .take_dst   (tx_dst),
    .give_en    (from_me),
    .give_dst   (ring_in_dst),
    .query_dst  (tx_dst),
    .has_credit (has_credit),
    .cred_vec   (cred_vec)
  );

  assign ring_out_vld  = out_word.vld;
  assign ring_out_src  = out_word.src;
  assign ring_out_dst  = out_word.dst;
  assign ring_out_data = out_word.data;
endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk
  import ring_pkg::*;
#(
  parameter int NODE_ID = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ring_in_vld,
  input logic [RING_ID_W-1:0]   ring_in_src,
  input logic [RING_ID_W-1:0]   ring_in_dst,
  input logic [RING_DATA_W-1:0] ring_in_data,
  input logic                   ring_out_vld,
  input logic [RING_ID_W-1:0]   ring_out_src,
  input logic [RING_ID_W-1:0]   ring_out_dst,
  input logic [RING_DATA_W-1:0] ring_out_data,
  input logic                   tx_valid,
  input logic                   tx_ready,
  input logic [RING_ID_W-1:0]   tx_dst,
  input logic                   rx_rd,
  input logic [RING_ID_W-1:0]   rx_sel,
  input logic [RING_NODES-1:0]  rx_flags,
  input logic [RING_NODES-1:0]  cred_vec,
  input logic [RING_NODES-1:0]  ret_pend
);
  localparam logic [RING_ID_W-1:0] MY_ID = RING_ID_W'(NODE_ID);

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_vld && ring_in_src != MY_ID && ring_in_dst != MY_ID) |=> ##1
    (ring_out_vld && ring_out_src == $past(ring_in_src, 2) &&
     ring_out_dst == $past(ring_in_dst, 2) && ring_out_data == $past(ring_in_data, 2)));

  p_deliver_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_vld && ring_in_dst == MY_ID && ring_in_src != MY_ID) |=> rx_flags[$past(ring_in_src)]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_vld && ring_in_dst == MY_ID && ring_in_src != MY_ID) |->
    (!rx_flags[ring_in_src] && !ret_pend[ring_in_src]));

  p_credit_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_vld && ring_in_src == MY_ID) |=> cred_vec[$past(ring_in_dst)]);

  p_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=>
    (ring_out_vld && ring_out_src == MY_ID && ring_out_dst == $past(tx_dst) && !cred_vec[$past(tx_dst)]));

  p_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_in_vld && ring_in_src != MY_ID && ring_in_dst != MY_ID) |=> !tx_ready);

  p_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_flags[rx_sel]) |=> (!rx_flags[$past(rx_sel)] && ret_pend[$past(rx_sel)]));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_flags[rx_sel] && !ret_pend[rx_sel]) |=> !ret_pend[$past(rx_sel)]);

  p_return_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pend != '0) |-> !tx_ready);

  p_no_self_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dst == MY_ID) |-> !tx_ready);
endmodule

bind ring_node ring_node_chk #(.NODE_ID(NODE_ID)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ring_in_vld   (ring_in_vld),
  .ring_in_src   (ring_in_src),
  .ring_in_dst   (ring_in_dst),
  .ring_in_data  (ring_in_data),
  .ring_out_vld  (ring_out_vld),
  .ring_out_src  (ring_out_src),
  .ring_out_dst  (ring_out_dst),
  .ring_out_data (ring_out_data),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_dst        (tx_dst),
  .rx_rd         (rx_rd),
  .rx_sel        (rx_sel),
  .rx_flags      (rx_flags),
  .cred_vec      (cred_vec),
  .ret_pend      (ret_pend)
);

// File: tb/sim_ring_node.sv
module sim_ring_node;
  import ring_pkg::*;
  localparam int ID = 3;
  localparam int N  = RING_NODES;

  // 250 MHz: 4 time-unit period (units taken as ns)
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic       i_vld;
  logic [4:0] i_src, i_dst;
  logic [7:0] i_dat;
  logic       t_val;
  logic [4:0] t_dst;
  logic [7:0] t_dat;
  logic       r_rd;
  logic [4:0] r_sel;

  logic       o_vld, t_rdy;
  logic [4:0] o_src, o_dst;
  logic [7:0] o_dat, r_dat;
  logic [N-1:0] r_flags;

  ring_node #(.NODE_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ring_in_vld(i_vld), .ring_in_src(i_src), .ring_in_dst(i_dst), .ring_in_data(i_dat),
    .ring_out_vld(o_vld), .ring_out_src(o_src), .ring_out_dst(o_dst), .ring_out_data(o_dat),
    .tx_valid(t_val), .tx_ready(t_rdy), .tx_dst(t_dst), .tx_data(t_dat),
    .rx_rd(r_rd), .rx_sel(r_sel), .rx_data(r_dat), .rx_flags(r_flags)
  );

  // Behavioural reference state
  bit         m_cred [N];
  bit         m_flag [N];
  logic [7:0] m_buf  [N];
  bit         m_pend [N];
  logic [18:0] m_mid, m_out;
  logic [18:0] lb_q[$];
  int compared = 0, mismatched = 0;

  function automatic logic [18:0] mk(bit v, int s, int d, int x);
    return {v, s[4:0], d[4:0], x[7:0]};
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr();
    i_vld = 0; i_src = 0; i_dst = 0; i_dat = 0;
    t_val = 0; t_dst = 0; t_dat = 0; r_rd = 0; r_sel = 0;
  endtask

  // Compare this cycle, advance the model to the next edge.
  task automatic tick();
    bit exp_rdy, any_pend, rd_ok;
    int lo;
    logic [18:0] nxt_out, nxt_mid;
    logic [31:0] fl;
    #1;
    any_pend = 0; lo = -1;
    for (int k = N - 1; k >= 0; k--) if (m_pend[k]) begin any_pend = 1; lo = k; end
    exp_rdy = !m_mid[18] && !any_pend && m_cred[t_dst];
    fl = '0;
    for (int k = 0; k < N; k++) fl[k] = m_flag[k];
    if (m_out[18]) cmp("ring out word R2 R5 R7 R9", {13'd0, o_vld, o_src, o_dst, o_dat}, {13'd0, m_out});
    else           cmp("ring out idle R1 R4 R8", {31'd0, o_vld}, 32'd0);
    cmp("tx_ready R1 R4 R5 R6 R9 R10", {31'd0, t_rdy}, {31'd0, exp_rdy});
    cmp("rx_flags R1 R3 R7 R8", r_flags, fl);
    cmp("rx_data R3", {24'd0, r_dat}, {24'd0, m_buf[r_sel]});
    // next state
    rd_ok = r_rd && m_flag[r_sel];
    if (m_mid[18]) nxt_out = m_mid;
    else if (any_pend) begin
      nxt_out = mk(1, lo, ID, m_buf[lo]);
      m_pend[lo] = 0;
    end else if (t_val && exp_rdy) begin
      nxt_out = mk(1, ID, t_dst, t_dat);
      m_cred[t_dst] = 0;
      lb_q.push_back(nxt_out);
    end else nxt_out = '0;
    nxt_mid = '0;
    if (i_vld && i_src == ID) m_cred[i_dst] = 1;
    else if (i_vld && i_dst == ID) begin m_buf[i_src] = i_dat; m_flag[i_src] = 1; end
    else if (i_vld) nxt_mid = mk(1, i_src, i_dst, i_dat);
    if (rd_ok) begin m_flag[r_sel] = 0; m_pend[r_sel] = 1; end
    m_out = nxt_out; m_mid = nxt_mid;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ring(int s, int d, int x);
    i_vld = 1; i_src = s[4:0]; i_dst = d[4:0]; i_dat = x[7:0];
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin clr(); tick(); end
  endtask

  task automatic ret_next();
    logic [18:0] w;
    clr();
    w = lb_q.pop_front();
    ring(w[17:13], w[12:8], w[7:0]);
    tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1 act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      m_cred[k] = (k != ID); m_flag[k] = 0; m_buf[k] = 0; m_pend[k] = 0;
    end
    m_mid = '0; m_out = '0;
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    idle(3);

    // R2: back-to-back pass-through words
    clr(); ring(1, 7, 'hA1); tick();
    clr(); ring(6, 0, 'hB2); tick();
    clr(); ring(9, 12, 'hC3); tick();
    idle(3);

    // R5: send, then second send to same destination blocked
    clr(); t_val = 1; t_dst = 5; t_dat = 'h55; tick();
    clr(); t_val = 1; t_dst = 5; t_dat = 'h56; tick();
    idle(2);
    // R4: return restores credit
    ret_next();
    clr(); t_val = 1; t_dst = 5; t_dat = 'h57; tick();
    idle(2);
    ret_next();
    idle(1);

    // R6: sends wait for an empty slot
    clr(); ring(1, 7, 'h11); tick();
    clr(); ring(2, 8, 'h12); t_val = 1; t_dst = 8; t_dat = 'h80; tick();
    clr(); t_val = 1; t_dst = 8; t_dat = 'h80; tick();
    clr(); t_val = 1; t_dst = 8; t_dat = 'h80; tick();
    idle(2);
    ret_next();

    // R3: deliveries from two senders, view both slots
    clr(); ring(9, ID, 'h99); tick();
    clr(); ring(2, ID, 'h22); tick();
    clr(); r_sel = 9; tick();
    clr(); r_sel = 2; tick();

    // R7 R9: reads while ring is busy, returns leave lowest first, then send
    clr(); ring(1, 7, 'h31); r_rd = 1; r_sel = 9; tick();
    clr(); ring(4, 6, 'h32); r_rd = 1; r_sel = 2; t_val = 1; t_dst = 10; t_dat = 'hA0; tick();
    for (int k = 0; k < 6; k++) begin
      clr(); if (k == 0) ring(5, 1, 'h33);
      t_val = 1; t_dst = 10; t_dat = 'hA0; tick();
    end
    idle(2);
    ret_next();

    // R8: read of an empty slot
    clr(); r_rd = 1; r_sel = 20; tick();
    idle(3);

    // R10: own ID never ready
    for (int k = 0; k < 3; k++) begin clr(); t_val = 1; t_dst = ID; t_dat = 'h33; tick(); end

    // R4: destination no stop owns comes back and refunds credit
    clr(); t_val = 1; t_dst = 31; t_dat = 'hEE; tick();
    idle(2);
    ret_next();
    clr(); t_val = 1; t_dst = 31; t_dat = 'hEF; tick();
    idle(2);
    ret_next();

    // Mixed traffic R2 R3 R4 R5 R6 R7 R8 R9
    for (int c = 0; c < 600; c++) begin
      int r, s, d;
      clr();
      r = $urandom % 8;
      if (lb_q.size() != 0 && r < 3) begin
        logic [18:0] w;
        w = lb_q.pop_front();
        ring(w[17:13], w[12:8], w[7:0]);
      end else if (r < 5) begin
        s = $urandom % N; d = $urandom % N;
        if (s == ID) s = 0;
        if (d == ID) d = 1;
        ring(s, d, $urandom % 256);
      end else if (r == 5) begin
        s = $urandom % N;
        if (s != ID && !m_flag[s] && !m_pend[s]) ring(s, ID, $urandom % 256);
      end
      t_val = ($urandom % 2) == 1;
      t_dst = 5'($urandom % N);
      t_dat = 8'($urandom % 256);
      r_rd  = ($urandom % 3) == 0;
      r_sel = 5'($urandom % N);
      tick();
    end
    while (lb_q.size() != 0) ret_next();
    idle(12);

    summary();
    $finish;
  end
endmodule